// File: doc/BRIEF.md
# Rotated Frame-Scan Parameter Calculator

This block turns a framebuffer base address and a set of scan settings into the parameters a two-level (element/frame) address generator needs to read a frame out of memory rotated by 0, 90, 180 or 270 degrees, optionally mirrored. The settings are the visible width and height in pixels, the line pitch in pixels (virtual width), horizontal and vertical scale factors, an element size code and a rotation code with a mirror flag. The results are the address of the first and last pixel read, a signed element step and a signed frame step, the number of elements per frame and the number of frames, and a flag saying whether the simple linear scan suffices or double-indexed addressing is needed.

The computation is sequential. A one-cycle `start` pulse captures all settings; the block then checks them, walks six pixel coordinates through a single shared address path, and finally pulses `done` with the results on its outputs. Bad settings produce an `err` pulse instead, and the previous results remain on the outputs. Loading the results into a transfer engine is left to the surrounding logic.

Top module: `rotscan_param_calc`

## Requirements
- R1: After a synchronous active-low reset, busy, done and err are low and all result outputs are zero.
- R2: With the block idle, a start pulse is accepted on the clock edge where it is high; busy is high from the next cycle; on a good setting done is high for exactly one cycle, 8 edges after the accepting edge, with busy low in that cycle; results change only in a done cycle and hold otherwise.
- R3: A start pulse while busy is ignored: the running calculation completes with the settings captured first.
- R4: The byte offset of pixel (x,y) is (y*pitch*yscale + x*xscale)*bytes, where size code 0, 1, 2 gives 1, 2, 4 bytes; start_addr and end_addr are the base address plus this offset, modulo 2^AW.
- R5: A pitch of zero means the pitch equals the width; a zero x or y scale means a scale of 1.
- R6: A step from pixel A to pixel B is offset(B) - offset(A) - bytes + 1, as an AW-bit two's complement value.
- R7: Rotation code 0: unmirrored, start (0,0), end (w-1,h-1), element step (0,0)->(1,0), frame step (w-1,0)->(0,1); mirrored, start (w-1,0), end (0,h-1), element step (1,0)->(0,0), frame step (0,0)->(w-1,1).
- R8: Rotation code 1 (90 degrees): unmirrored, start (0,h-1), end (w-1,0), element step (0,1)->(0,0), frame step (0,0)->(1,h-1); mirrored, start (w-1,h-1), end (0,0), element step (0,1)->(0,0), frame step (1,0)->(0,h-1).
- R9: Rotation code 2 (180 degrees): unmirrored, start (w-1,h-1), end (0,0), element step (1,0)->(0,0), frame step (0,1)->(w-1,0); mirrored, start (0,h-1), end (w-1,0), element step (0,0)->(1,0), frame step (w-1,1)->(0,0).
- R10: Rotation code 3 (270 degrees): unmirrored, start (w-1,0), end (0,h-1), element step (0,0)->(0,1), frame step (1,h-1)->(0,0); mirrored, start (0,0), end (w-1,h-1), element step (0,0)->(0,1), frame step (0,h-1)->(1,0).
- R11: For rotation codes 0 and 2 the element count is w and the frame count h; for codes 1 and 3 they are h and w.
- R12: double_idx is high exactly when the rotation code is nonzero, mirror is set, or the raw pitch, x scale or y scale input is nonzero.
- R13: Size code 3, a rotation code of 4 to 7, a zero width or height, or an effective pitch below the width makes err pulse for one cycle, 1 edge after the accepting edge, with no done pulse and all result outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calculation (taken only when idle) |
| base_addr | input | AW | Byte address of pixel (0,0) |
| width | input | DW | Visible width in pixels |
| height | input | DW | Visible height in pixels |
| pitch | input | DW | Line pitch in pixels, 0 = width |
| xscale | input | SW | Horizontal scale, 0 = 1 |
| yscale | input | SW | Vertical scale, 0 = 1 |
| size_code | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: invalid |
| rot_code | input | 3 | 0/1/2/3 = 0/90/180/270 degrees, others invalid |
| mirror | input | 1 | Mirror the scan |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| err | output | 1 | One-cycle pulse, settings rejected |
| start_addr | output | AW | Address of first pixel read |
| end_addr | output | AW | Address of last pixel read |
| elem_step | output | AW | Encoded signed element step |
| frame_step | output | AW | Encoded signed frame step |
| elem_count | output | DW | Elements per frame |
| frame_count | output | DW | Number of frames |
| double_idx | output | 1 | Double-indexed addressing needed |

## Verification
The assertions watch the handshake on every cycle: done and err are single-cycle and exclusive, busy only rises after a start, done ends a busy period, and the result outputs never move outside a done cycle, including across an err pulse. What the outputs hold after done (the corner and step values of all eight rotation and mirror combinations, the defaulting of zero pitch and scales, the element size scaling, the counts and the double-indexed flag) and the exact latencies can only be shown by the bench's directed scenarios, which compare each output against values derived from the requirements.

// File: rtl/rotscan_pkg.sv
// Shared constants and types for the rotated frame-scan parameter calculator.
// Assumes nothing beyond IEEE 1800-2017.
package rotscan_pkg;

    // Controller states: capture, validate, walk points, publish.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_CALC  = 2'd2,
        ST_FIN   = 2'd3
    } calc_state_e;

    // Points walked per calculation: start, end, element pair, frame pair.
    localparam int NUM_PTS   = 6;
    localparam int PT_START  = 0;
    localparam int PT_END    = 1;
    localparam int PT_EFROM  = 2;
    localparam int PT_ETO    = 3;
    localparam int PT_FFROM  = 4;
    localparam int PT_FTO    = 5;

    localparam logic [1:0] SIZE_INVALID = 2'd3;
    localparam logic [2:0] ROT_MAX      = 3'd3;

endpackage

// File: rtl/scan_setting_check.sv
// Normalises the captured scan settings and judges them.
// Zero pitch falls back to the width, zero scales fall back to one.
// Assumes the settings are held stable while it is used (purely combinational).
module scan_setting_check
    import rotscan_pkg::*;
#(
    parameter int DW = 12,
    parameter int SW = 4
) (
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [DW-1:0] pitch,
    input  logic [SW-1:0] xscale,
    input  logic [SW-1:0] yscale,
    input  logic [1:0]    size_code,
    input  logic [2:0]    rot_code,
    input  logic          mirror,
    output logic [DW-1:0] eff_pitch,
    output logic [SW-1:0] eff_xs,
    output logic [SW-1:0] eff_ys,
    output logic [1:0]    size_shift,
    output logic          bad,
    output logic          dbl
);

    // Substitute defaults for zero-valued settings.
    always_comb begin
        eff_pitch  = (pitch  == '0) ? width : pitch;
        eff_xs     = (xscale == '0) ? SW'(1) : xscale;
        eff_ys     = (yscale == '0) ? SW'(1) : yscale;
        size_shift = size_code;
    end

    // Reject unusable settings and decide whether two-level indexing is needed.
    always_comb begin
        bad = (size_code == SIZE_INVALID) || (rot_code > ROT_MAX) ||
              (width == '0) || (height == '0) || (eff_pitch < width);
        dbl = (rot_code != '0) || mirror || (pitch != '0) ||
              (xscale != '0) || (yscale != '0);
    end

endmodule

// File: rtl/scan_corner_map.sv
// Gives, for one rotation and mirror choice, the six pixel coordinates the
// calculator needs: first pixel, last pixel, element step source and target,
// frame step source and target. Assumes width and height are nonzero.
module scan_corner_map
    import rotscan_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [1:0]    rot,
    input  logic          mirror,
    output logic [DW-1:0] pt_x [NUM_PTS],
    output logic [DW-1:0] pt_y [NUM_PTS]
);

    logic [DW-1:0] zr, on, wm, hm;

    // Named coordinate values used by the table below.
    always_comb begin
        zr = '0;
        on = DW'(1);
        wm = width - DW'(1);
        hm = height - DW'(1);
    end

    // Coordinate table; order in each row: start, end, e-from, e-to, f-from, f-to.
    always_comb begin
        case ({rot, mirror})
            3'b000: begin
                pt_x = '{zr, wm, zr, on, wm, zr};
                pt_y = '{zr, hm, zr, zr, zr, on};
            end
            3'b001: begin
                pt_x = '{wm, zr, on, zr, zr, wm};
                pt_y = '{zr, hm, zr, zr, zr, on};
            end
            3'b010: begin
                pt_x = '{zr, wm, zr, zr, zr, on};
                pt_y = '{hm, zr, on, zr, zr, hm};
            end
            3'b011: begin
                pt_x = '{wm, zr, zr, zr, on, zr};
                pt_y = '{hm, zr, on, zr, zr, hm};
            end
            3'b100: begin
                pt_x = '{wm, zr, on, zr, zr, wm};
                pt_y = '{hm, zr, zr, zr, on, zr};
            end
            3'b101: begin
                pt_x = '{zr, wm, zr, on, wm, zr};
                pt_y = '{hm, zr, zr, zr, on, zr};
            end
            3'b110: begin
                pt_x = '{wm, zr, zr, zr, on, zr};
                pt_y = '{zr, hm, zr, on, hm, zr};
            end
            default: begin
                pt_x = '{zr, wm, zr, zr, zr, on};
                pt_y = '{zr, hm, zr, on, hm, zr};
            end
        endcase
    end

endmodule

// File: rtl/scan_pixel_offset.sv
// Byte offset of one pixel from the frame base:
// (y * pitch * yscale + x * xscale) shifted by the element size code.
// All arithmetic wraps at AW bits. Expects already-defaulted pitch and scales.
module scan_pixel_offset #(
    parameter int DW = 12,
    parameter int SW = 4,
    parameter int AW = 32
) (
    input  logic [DW-1:0] px,
    input  logic [DW-1:0] py,
    input  logic [DW-1:0] pitch,
    input  logic [SW-1:0] xs,
    input  logic [SW-1:0] ys,
    input  logic [1:0]    shift,
    output logic [AW-1:0] offset
);

    logic [AW-1:0] row_part;
    logic [AW-1:0] col_part;

    // Row and column contributions, then element size scaling.
    always_comb begin
        row_part = AW'(py) * AW'(pitch) * AW'(ys);
        col_part = AW'(px) * AW'(xs);
        offset   = (row_part + col_part) << shift;
    end

endmodule

// File: rtl/rotscan_param_calc.sv
// Rotated frame-scan parameter calculator (top).
// Captures settings on an accepted start, validates them in one cycle, walks
// six pixel coordinates through one shared offset path (one per cycle), and
// publishes addresses, encoded steps and counts with a done pulse. Invalid
// settings give an err pulse and leave the published results untouched.
// Assumes start is a pulse; starts while busy are dropped.
module rotscan_param_calc
    import rotscan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 12,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [DW-1:0] pitch,
    input  logic [SW-1:0] xscale,
    input  logic [SW-1:0] yscale,
    input  logic [1:0]    size_code,
    input  logic [2:0]    rot_code,
    input  logic          mirror,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr,
    output logic [AW-1:0] elem_step,
    output logic [AW-1:0] frame_step,
    output logic [DW-1:0] elem_count,
    output logic [DW-1:0] frame_count,
    output logic          double_idx
);

    localparam int IW       = $clog2(NUM_PTS);
    localparam int LAST_IDX = NUM_PTS - 1;
    localparam int NUM_STEP = 2;

    calc_state_e   state;
    logic [IW-1:0] idx;

    // Captured settings.
    logic [AW-1:0] base_q;
    logic [DW-1:0] w_q, h_q, pitch_q;
    logic [SW-1:0] xs_q, ys_q;
    logic [1:0]    size_q;
    logic [2:0]    rot_q;
    logic          mir_q;

    // Normalised settings and verdict.
    logic [DW-1:0] eff_pitch;
    logic [SW-1:0] eff_xs, eff_ys;
    logic [1:0]    size_shift;
    logic          bad, dbl;

    logic [DW-1:0] pt_x [NUM_PTS];
    logic [DW-1:0] pt_y [NUM_PTS];
    logic [DW-1:0] cur_x, cur_y;
    logic [AW-1:0] cur_off;
    logic [AW-1:0] off_q [NUM_PTS];
    logic [AW-1:0] elem_bytes;
    logic [AW-1:0] step_val [NUM_STEP];

    scan_setting_check #(.DW(DW), .SW(SW)) i_check (
        .width      (w_q),
        .height     (h_q),
        .pitch      (pitch_q),
        .xscale     (xs_q),
        .yscale     (ys_q),
        .size_code  (size_q),
        .rot_code   (rot_q),
        .mirror     (mir_q),
        .eff_pitch  (eff_pitch),
        .eff_xs     (eff_xs),
        .eff_ys     (eff_ys),
        .size_shift (size_shift),
        .bad        (bad),
        .dbl        (dbl)
    );

    scan_corner_map #(.DW(DW)) i_corners (
        .width  (w_q),
        .height (h_q),
        .rot    (rot_q[1:0]),
        .mirror (mir_q),
        .pt_x   (pt_x),
        .pt_y   (pt_y)
    );

    // Pick the coordinate for the current walk position.
    always_comb begin
        cur_x = '0;
        cur_y = '0;
        for (int i = 0; i < NUM_PTS; i++) begin
            if (idx == IW'(i)) begin
                cur_x = pt_x[i];
                cur_y = pt_y[i];
            end
        end
    end

    scan_pixel_offset #(.DW(DW), .SW(SW), .AW(AW)) i_offset (
        .px     (cur_x),
        .py     (cur_y),
        .pitch  (eff_pitch),
        .xs     (eff_xs),
        .ys     (eff_ys),
        .shift  (size_shift),
        .offset (cur_off)
    );

    // Element size in bytes, used by the step encoding.
    always_comb elem_bytes = AW'(1) << size_shift;

    // Encoded steps: element pair first, frame pair second.
    for (genvar g = 0; g < NUM_STEP; g++) begin : g_step
        always_comb step_val[g] = off_q[PT_ETO + 2*g] - off_q[PT_EFROM + 2*g]
                                  - elem_bytes + AW'(1);
    end

    // Busy covers every non-idle state.
    always_comb busy = (state != ST_IDLE);

    // Controller: capture, check, walk, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            idx         <= '0;
            done        <= 1'b0;
            err         <= 1'b0;
            base_q      <= '0;
            w_q         <= '0;
            h_q         <= '0;
            pitch_q     <= '0;
            xs_q        <= '0;
            ys_q        <= '0;
            size_q      <= '0;
            rot_q       <= '0;
            mir_q       <= 1'b0;
            start_addr  <= '0;
            end_addr    <= '0;
            elem_step   <= '0;
            frame_step  <= '0;
            elem_count  <= '0;
            frame_count <= '0;
            double_idx  <= 1'b0;
            for (int i = 0; i < NUM_PTS; i++) off_q[i] <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= base_addr;
                        w_q     <= width;
                        h_q     <= height;
                        pitch_q <= pitch;
                        xs_q    <= xscale;
                        ys_q    <= yscale;
                        size_q  <= size_code;
                        rot_q   <= rot_code;
                        mir_q   <= mirror;
                        state   <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    idx <= '0;
                    if (bad) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    for (int i = 0; i < NUM_PTS; i++) begin
                        if (idx == IW'(i)) off_q[i] <= cur_off;
                    end
                    if (idx == IW'(LAST_IDX)) state <= ST_FIN;
                    else                      idx   <= idx + IW'(1);
                end
                ST_FIN: begin
                    start_addr  <= base_q + off_q[PT_START];
                    end_addr    <= base_q + off_q[PT_END];
                    elem_step   <= step_val[0];
                    frame_step  <= step_val[1];
                    elem_count  <= rot_q[0] ? h_q : w_q;
                    frame_count <= rot_q[0] ? w_q : h_q;
                    double_idx  <= dbl;
                    done        <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rotscan_checker.sv
// Handshake and result-hold properties for rotscan_param_calc, bound to it.
module rotscan_checker #(
    parameter int AW = 32,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] start_addr,
    input logic [AW-1:0] end_addr,
    input logic [AW-1:0] elem_step,
    input logic [AW-1:0] frame_step,
    input logic [DW-1:0] elem_count,
    input logic [DW-1:0] frame_count,
    input logic          double_idx
);

    // R2: done and err never appear together.
    assert_done_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);

    // R2: done lasts one cycle.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: err lasts one cycle.
    assert_err_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R2: done closes a busy period.
    assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R2: busy only rises after a start was offered.
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(start));

    // R2 and R13: results move only in a done cycle.
    assert_results_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(start_addr) && $stable(end_addr) &&
                   $stable(elem_step) && $stable(frame_step) &&
                   $stable(elem_count) && $stable(frame_count) &&
                   $stable(double_idx)));

endmodule

bind rotscan_param_calc rotscan_checker #(.AW(AW), .DW(DW)) i_rotscan_checker (.*);

// File: tb/test_rotscan_param_calc.sv
// Directed bench for rotscan_param_calc: one task per scenario.
module test_rotscan_param_calc;

    localparam int AW = 32;
    localparam int DW = 12;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [DW-1:0] width = '0, height = '0, pitch = '0;
    logic [SW-1:0] xscale = '0, yscale = '0;
    logic [1:0]    size_code = '0;
    logic [2:0]    rot_code = '0;
    logic          mirror = 1'b0;
    logic          busy, done, err, double_idx;
    logic [AW-1:0] start_addr, end_addr, elem_step, frame_step;
    logic [DW-1:0] elem_count, frame_count;

    int n_checks = 0;
    int n_fail   = 0;

    rotscan_param_calc #(.AW(AW), .DW(DW), .SW(SW)) i_rotscan_param_calc (
        .clk, .rst_n, .start, .base_addr, .width, .height, .pitch,
        .xscale, .yscale, .size_code, .rot_code, .mirror,
        .busy, .done, .err, .start_addr, .end_addr, .elem_step,
        .frame_step, .elem_count, .frame_count, .double_idx
    );

    always #5 clk = ~clk;

    task automatic chk(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Pixel byte offset per R4 with R5 defaults already applied by caller.
    function automatic longint pix(longint x, longint y, longint pw, longint sx,
                                   longint sy, longint nb);
        return (y * pw * sy + x * sx) * nb;
    endfunction

    // Coordinate of a named point for a rotation/mirror choice (R7..R10).
    // sel: 0 start, 1 end, 2 e-from, 3 e-to, 4 f-from, 5 f-to.
    function automatic void corner(int r, bit m, int sel, longint w, longint h,
                                   output longint x, output longint y);
        longint a = w - 1;
        longint b = h - 1;
        x = 0; y = 0;
        if (r == 0 && !m) begin
            case (sel) 1: begin x = a; y = b; end 3: x = 1; 4: x = a; 5: y = 1; default: ; endcase
        end else if (r == 0) begin
            case (sel) 0: x = a; 1: y = b; 2: x = 1; 5: begin x = a; y = 1; end default: ; endcase
        end else if (r == 1 && !m) begin
            case (sel) 0: y = b; 1: x = a; 2: y = 1; 5: begin x = 1; y = b; end default: ; endcase
        end else if (r == 1) begin
            case (sel) 0: begin x = a; y = b; end 2: y = 1; 4: x = 1; 5: y = b; default: ; endcase
        end else if (r == 2 && !m) begin
            case (sel) 0: begin x = a; y = b; end 2: x = 1; 4: y = 1; 5: x = a; default: ; endcase
        end else if (r == 2) begin
            case (sel) 0: y = b; 1: x = a; 3: x = 1; 4: begin x = a; y = 1; end default: ; endcase
        end else if (r == 3 && !m) begin
            case (sel) 0: x = a; 1: y = b; 3: y = 1; 4: begin x = 1; y = b; end default: ; endcase
        end else begin
            case (sel) 1: begin x = a; y = b; end 3: y = 1; 4: y = b; 5: x = 1; default: ; endcase
        end
    endfunction

    task automatic drive(longint b, int w, int h, int pw, int sx, int sy,
                         int sz, int r, bit m);
        @(negedge clk);
        base_addr = AW'(b); width = DW'(w); height = DW'(h); pitch = DW'(pw);
        xscale = SW'(sx); yscale = SW'(sy); size_code = 2'(sz);
        rot_code = 3'(r); mirror = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Edges after the accepting edge until done or err shows.
    task automatic wait_result(output int edges);
        edges = 0;
        while (!(done || err) && edges < 40) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
    endtask

    // Compare every result output against the requirement model.
    task automatic check_results(string tag, longint b, int w, int h, int pw,
                                 int sx, int sy, int sz, int r, bit m);
        longint epw = (pw == 0) ? w : pw;
        longint ex = (sx == 0) ? 1 : sx;
        longint ey = (sy == 0) ? 1 : sy;
        longint nb = 1 << sz;
        longint msk = (64'd1 << AW) - 1;
        longint x0, y0, x1, y1;
        longint o[6];
        for (int s = 0; s < 6; s++) begin
            corner(r, m, s, w, h, x0, y0);
            o[s] = pix(x0, y0, epw, ex, ey, nb);
        end
        x1 = 0; y1 = 0;
        chk({tag, " R4"}, "start_addr", start_addr, (b + o[0]) & msk);
        chk({tag, " R4"}, "end_addr", end_addr, (b + o[1]) & msk);
        chk({tag, " R6"}, "elem_step", elem_step, (o[3] - o[2] - nb + 1) & msk);
        chk({tag, " R6"}, "frame_step", frame_step, (o[5] - o[4] - nb + 1) & msk);
        chk({tag, " R11"}, "elem_count", elem_count, (r % 2 == 1) ? h : w);
        chk({tag, " R11"}, "frame_count", frame_count, (r % 2 == 1) ? w : h);
        chk({tag, " R12"}, "double_idx", double_idx,
            (r != 0 || m || pw != 0 || sx != 0 || sy != 0) ? 1 : 0);
        if (x1 != y1) $display("unreachable");
    endtask

    task automatic run_good(string tag, longint b, int w, int h, int pw, int sx,
                            int sy, int sz, int r, bit m);
        int edges;
        drive(b, w, h, pw, sx, sy, sz, r, m);
        chk({tag, " R2"}, "busy after start", busy, 1);
        wait_result(edges);
        chk({tag, " R2"}, "done latency", edges, 8);
        chk({tag, " R2"}, "done high", done, 1);
        chk({tag, " R2"}, "busy in done cycle", busy, 0);
        check_results(tag, b, w, h, pw, sx, sy, sz, r, m);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2"}, "done one cycle", done, 0);
    endtask

    task automatic test_reset;
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "err", err, 0);
        chk("R1", "start_addr", start_addr, 0);
        chk("R1", "frame_step", frame_step, 0);
        chk("R1", "elem_count", elem_count, 0);
        chk("R1", "double_idx", double_idx, 0);
    endtask

    task automatic test_rotations;
        // R7 R8 R9 R10: every rotation and mirror choice, unequal w and h.
        for (int r = 0; r < 4; r++) begin
            for (int m = 0; m < 2; m++) begin
                run_good($sformatf("R%0d m%0d", 7 + r, m), 64'h1000_0000,
                         5, 3, 8, 2, 3, 1, r, bit'(m));
            end
        end
    endtask

    task automatic test_defaults;
        // R5: zero pitch/scales equal explicit width and 1; R12 flag low only here.
        run_good("R5 zero", 64'h0020_0000, 7, 4, 0, 0, 0, 1, 0, 1'b0);
        run_good("R5 explicit", 64'h0020_0000, 7, 4, 7, 1, 1, 1, 0, 1'b0);
        run_good("R5 rot", 64'h0020_0000, 7, 4, 0, 0, 0, 0, 1, 1'b0);
    endtask

    task automatic test_sizes;
        // R4: byte, halfword and word elements; wrap near top of address space.
        run_good("R4 byte", 64'h0000_4000, 10, 6, 16, 0, 0, 0, 2, 1'b1);
        run_good("R4 word", 64'hFFFF_FF00, 10, 6, 16, 1, 2, 2, 3, 1'b0);
        run_good("R4 single", 64'h0000_0100, 1, 1, 0, 0, 0, 2, 1, 1'b1);
    endtask

    task automatic run_bad(string tag, int w, int h, int pw, int sz, int r);
        int edges;
        logic [AW-1:0] sa, fs;
        logic [DW-1:0] ec;
        sa = start_addr; fs = frame_step; ec = elem_count;
        drive(64'h0BAD_0000, w, h, pw, 0, 0, sz, r, 1'b0);
        wait_result(edges);
        chk({tag, " R13"}, "err latency", edges, 1);
        chk({tag, " R13"}, "err high", err, 1);
        chk({tag, " R13"}, "no done", done, 0);
        repeat (10) begin
            @(posedge clk);
            @(negedge clk);
            if (done) chk({tag, " R13"}, "late done", done, 0);
        end
        chk({tag, " R13"}, "start_addr kept", start_addr, sa);
        chk({tag, " R13"}, "frame_step kept", frame_step, fs);
        chk({tag, " R13"}, "elem_count kept", elem_count, ec);
        chk({tag, " R13"}, "idle", busy, 0);
    endtask

    task automatic test_errors;
        run_good("R13 prime", 64'h0000_8000, 4, 4, 0, 0, 0, 1, 2, 1'b0);
        run_bad("size3", 4, 4, 0, 3, 0);
        run_bad("rot5", 4, 4, 0, 1, 5);
        run_bad("pitch", 8, 4, 6, 1, 0);
        run_bad("zero h", 8, 0, 0, 1, 0);
    endtask

    task automatic test_busy_ignore;
        int edges;
        drive(64'h0003_0000, 6, 5, 0, 0, 0, 1, 1, 1'b0);
        @(negedge clk);
        base_addr = 32'h7777_0000; width = 12'd9; rot_code = 3'd2; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        edges = 2;
        while (!(done || err) && edges < 40) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
        chk("R3", "done latency from first start", edges, 8);
        check_results("R3", 64'h0003_0000, 6, 5, 0, 0, 0, 1, 1, 1'b0);
        repeat (12) begin
            @(posedge clk);
            @(negedge clk);
            if (done || busy) chk("R3", "second start ran", 1, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_rotations();
        test_defaults();
        test_sizes();
        test_errors();
        test_busy_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule